// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. Software starts a conversion with a start request. The block then opens the track/hold switch so the sample is frozen. It steps a trial code through a DAC, reading one comparator decision in each conversion-clock period. The highest bit is decided first.

The conversion-clock period comes from one of two sources. It is either a power-of-two division of the system clock, chosen by a 3-bit select field, or the rising edges of a separate free-running clock. The free-running clock is synchronized before use. That clock is the one to use for conversions that must proceed while the system clock is stopped in a low-power state.

A frame lasts eleven periods. The first is a setup period. Each of the other ten resolves one bit. One system-clock cycle after the last period, four things happen together: the result pair is loaded, the busy/start bit drops, a sticky completion flag is raised and the track/hold switch closes again. Software can abandon a conversion, either by clearing the start bit or by disabling the converter.

Top module: `sar_seq`

## Requirements
- R1: Select codes map to conversion-clock periods of 2, 4, 8, 16, 32 and 64 system cycles for codes 000, 100, 001, 101, 010 and 110. The busy bit falls exactly 11*div+1 cycles after the edge that accepts the start request.
- R2: A select code whose two low bits are 11 times periods from rising edges of the synchronized free-running clock, and not from the divider. While that clock is stopped, a conversion does not progress.
- R3: A start request is accepted only when the converter is enabled and idle. On the accepting edge, busy (go_bit) and hold_open both go to 1. A start request while disabled or busy has no effect.
- R4: Bits are resolved from bit 9 down to bit 0. Each trial sets the bit under test, and the bit is kept when cmp_in is 1 (input at or above the DAC output). With an ideal comparator, the final result equals the input level.
- R5: On the edge after the end of the eleventh period, the result is loaded, go_bit and hold_open go to 0, and done_flag goes to 1, all on the same edge.
- R6: The result is presented as result_hi (bits 9:8) and result_lo (bits 7:0). It keeps its previous value for the whole of a conversion.
- R7: Pulsing go_clr, or dropping en, during a conversion aborts it on the next edge. go_bit and hold_open go to 0, and the result and done_flag are left unchanged.
- R8: done_flag stays 1 until a flag_clr pulse. A completion on the same edge as flag_clr leaves it at 1.
- R9: After reset, go_bit, hold_open, dac_code, the result and done_flag are all 0.
- R10: dac_code is 0 while idle and during the setup period. It becomes 10'h200 at the end of the setup period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_clk | input | 1 | Free-running conversion clock, asynchronous |
| en | input | 1 | Converter enable |
| clk_sel | input | 3 | Conversion clock select |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Abort request pulse |
| flag_clr | input | 1 | Clears the completion flag |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above DAC |
| go_bit | output | 1 | Conversion in progress |
| hold_open | output | 1 | Track/hold switch open (sample isolated) |
| dac_code | output | 10 | Trial code to the DAC |
| result_hi | output | 2 | Result bits 9:8 |
| result_lo | output | 8 | Result bits 7:0 |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach from the ports is a conversion timed by the free-running clock while that clock is held still. The conversion must sit in mid-frame and ignore the system-clock divider completely. The bench gets there by stopping its free-running clock generator before a start with select code 111. It then waits far longer than any divided frame and confirms that go_bit is still 1. Finally it restarts the clock and checks that the conversion finishes with the correct code. Aborts are placed deep inside a slow frame, so the untouched result and flag can be told apart from a completion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_BITS  = 10;
    localparam int SEL_W     = 3;
    localparam int MAX_SHIFT = 6;
    localparam int CNT_W     = MAX_SHIFT;
    localparam int POS_W     = $clog2(RES_BITS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RESOLVE,
        ST_FINISH
    } conv_state_t;

    typedef struct packed {
        logic       use_alt;
        logic [2:0] shift;
    } clk_cfg_t;

    // Decode the select field: low bits 11 pick the free-running clock,
    // otherwise the division exponent is {sel[1:0], sel[2]} + 1.
    function automatic clk_cfg_t decode_sel(input logic [SEL_W-1:0] sel);
        clk_cfg_t c;
        c.use_alt = (sel[1:0] == 2'b11);
        c.shift   = {sel[1:0], sel[2]} + 3'd1;
        return c;
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             alt_clk,
    output logic             tick
);
    localparam int SYNC_STAGES = 3;

    logic [SYNC_STAGES-1:0] alt_sync;
    logic                   alt_rise;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       div_last;
    logic [CNT_W:0]         div_full;
    clk_cfg_t               cfg;

    assign cfg      = decode_sel(sel);
    assign div_full = (CNT_W+1)'(1) << cfg.shift;
    assign div_last = CNT_W'(div_full - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) alt_sync <= '0;
        else     alt_sync <= {alt_sync[SYNC_STAGES-2:0], alt_clk};
    end

    assign alt_rise = alt_sync[SYNC_STAGES-2] & ~alt_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !run)          cnt <= '0;
        else if (cnt == div_last) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign tick = run && (cfg.use_alt ? alt_rise : (cnt == div_last));
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic                tick,
    input  logic                cmp,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] sar
);
    conv_state_t      state;
    logic [POS_W-1:0] pos;

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FINISH) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pos   <= '0;
            sar   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SETUP;
                        sar   <= '0;
                    end
                end
                ST_SETUP: begin
                    if (abort) begin
                        state <= ST_IDLE;
                        sar   <= '0;
                    end else if (tick) begin
                        state <= ST_RESOLVE;
                        sar   <= RES_BITS'(1) << (RES_BITS-1);
                        pos   <= POS_W'(RES_BITS-1);
                    end
                end
                ST_RESOLVE: begin
                    if (abort) begin
                        state <= ST_IDLE;
                        sar   <= '0;
                    end else if (tick) begin
                        sar[pos] <= cmp;
                        if (pos == '0) begin
                            state <= ST_FINISH;
                        end else begin
                            sar[pos - 1'b1] <= 1'b1;
                            pos             <= pos - 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    sar   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int LO_W = 8,
    localparam int HI_W = RES_BITS - LO_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alt_clk,
    input  logic                en,
    input  logic [SEL_W-1:0]    clk_sel,
    input  logic                go_set,
    input  logic                go_clr,
    input  logic                flag_clr,
    input  logic                cmp_in,
    output logic                go_bit,
    output logic                hold_open,
    output logic [RES_BITS-1:0] dac_code,
    output logic [HI_W-1:0]     result_hi,
    output logic [LO_W-1:0]     result_lo,
    output logic                done_flag
);
    logic                busy;
    logic                done;
    logic                tick;
    logic                start;
    logic                abort;
    logic [RES_BITS-1:0] sar;
    logic [RES_BITS-1:0] result_q;

    assign start = go_set && en && !busy;
    assign abort = busy && (go_clr || !en);

    sar_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .sel     (clk_sel),
        .alt_clk (alt_clk),
        .tick    (tick)
    );

    sar_core u_core (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .abort (abort),
        .tick  (tick),
        .cmp   (cmp_in),
        .busy  (busy),
        .done  (done),
        .sar   (sar)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q  <= '0;
            done_flag <= 1'b0;
        end else begin
            if (done)          result_q  <= sar;
            if (done)          done_flag <= 1'b1;
            else if (flag_clr) done_flag <= 1'b0;
        end
    end

    assign go_bit    = busy;
    assign hold_open = busy;
    assign dac_code  = sar;
    assign result_hi = result_q[RES_BITS-1:LO_W];
    assign result_lo = result_q[LO_W-1:0];
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker
    import sar_seq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                go_set,
    input logic                go_clr,
    input logic                flag_clr,
    input logic                go_bit,
    input logic                hold_open,
    input logic [RES_BITS-1:0] dac_code,
    input logic [RES_BITS-1:0] result,
    input logic                done_flag
);
    // R3: start while disabled has no effect
    assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(go_bit) && !$past(en)) |-> !go_bit);

    // R5: a completion (fall without abort) raises the flag and closes the switch
    assert_finish_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(go_bit) && $past(en) && !$past(go_clr)) |-> (done_flag && !hold_open));

    // R6: result stays still throughout a conversion
    assert_result_stable_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(go_bit) && go_bit) |-> $stable(result));

    // R7: abort leaves result and flag untouched
    assert_abort_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(go_bit) && $past(go_clr)) |-> ($stable(result) && !$rose(done_flag)));

    // R8: flag is sticky until cleared
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(done_flag) && !$past(flag_clr)) |-> done_flag);

    // R10: trial code is zero while idle
    assert_dac_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !go_bit |-> (dac_code == '0));

    // R3: acceptance opens the track/hold switch
    assert_start_opens_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(go_bit) |-> hold_open);
endmodule

bind sar_seq sar_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .go_set    (go_set),
    .go_clr    (go_clr),
    .flag_clr  (flag_clr),
    .go_bit    (go_bit),
    .hold_open (hold_open),
    .dac_code  (dac_code),
    .result    ({result_hi, result_lo}),
    .done_flag (done_flag)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alt_clk = 1'b0;
    logic       alt_run = 1'b1;
    logic       en = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       go_set = 1'b0;
    logic       go_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cmp_in;
    logic       go_bit, hold_open, done_flag;
    logic [9:0] dac_code;
    logic [1:0] result_hi;
    logic [7:0] result_lo;
    logic [9:0] vin = '0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;
    always #37 if (alt_run) alt_clk = ~alt_clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq u_dut (
        .clk(clk), .rst(rst), .alt_clk(alt_clk), .en(en), .clk_sel(clk_sel),
        .go_set(go_set), .go_clr(go_clr), .flag_clr(flag_clr), .cmp_in(cmp_in),
        .go_bit(go_bit), .hold_open(hold_open), .dac_code(dac_code),
        .result_hi(result_hi), .result_lo(result_lo), .done_flag(done_flag)
    );

    localparam logic [12:0] VEC [6] = '{
        {3'b000, 10'd0},   {3'b100, 10'd1023}, {3'b001, 10'd512},
        {3'b101, 10'd511}, {3'b010, 10'd341},  {3'b110, 10'd682}
    };

    function automatic int exp_div(input logic [2:0] s);
        case (s)
            3'b000: return 2;
            3'b100: return 4;
            3'b001: return 8;
            3'b101: return 16;
            3'b010: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [2:0] s, input logic [9:0] v);
        clk_sel = s; vin = v; go_set = 1'b1;
        @(negedge clk);
        go_set = 1'b0;
    endtask

    task automatic wait_idle(input int limit, output int n);
        n = 0;
        while (go_bit && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [9:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(!go_bit && !hold_open && dac_code == 0 && {result_hi, result_lo} == 0 && !done_flag,
            "R9 reset state", {go_bit, hold_open, done_flag}, 0);

        // R3 start ignored while disabled
        pulse_start(3'b000, 10'd5);
        chk(!go_bit, "R3 start while disabled", go_bit, 0);
        en = 1'b1;

        // table walk: R1, R4, R5, R6, R10
        foreach (VEC[i]) begin
            logic [2:0] s;
            logic [9:0] v;
            int d;
            s = VEC[i][12:10];
            v = VEC[i][9:0];
            d = exp_div(s);
            prev = {result_hi, result_lo};
            pulse_start(s, v);
            chk(go_bit && hold_open, "R3 accepted start", {go_bit, hold_open}, 3);
            n = 0;
            while (go_bit && n < 1000) begin
                if (n == d - 1) chk(dac_code == 0, "R10 setup code", dac_code, 0);
                if (n == d) chk(dac_code == 10'h200, "R10 first trial", dac_code, 512);
                if (n == 5 * d) chk({result_hi, result_lo} == prev, "R6 result held", {result_hi, result_lo}, prev);
                @(negedge clk);
                n++;
            end
            chk(n == 11 * d + 1, "R1 frame length", n, 11 * d + 1);
            chk({result_hi, result_lo} == v, "R4 result code", {result_hi, result_lo}, v);
            chk(result_hi == v[9:8] && result_lo == v[7:0], "R6 field split", result_hi, v[9:8]);
            chk(done_flag && !hold_open, "R5 completion", {done_flag, hold_open}, 2);
            repeat (3) @(negedge clk);
            chk(done_flag, "R8 flag sticky", done_flag, 1);
            flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
            chk(!done_flag, "R8 flag cleared", done_flag, 0);
        end

        // R3 start while busy ignored: frame length unchanged
        pulse_start(3'b100, 10'd300);
        repeat (10) @(negedge clk);
        go_set = 1'b1; @(negedge clk); go_set = 1'b0;
        wait_idle(1000, n);
        chk(n == 11 * 4 + 1 - 11, "R3 start while busy", n, 34);
        chk({result_hi, result_lo} == 10'd300, "R4 result after busy start", {result_hi, result_lo}, 300);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

        // R7 abort via go_clr
        prev = {result_hi, result_lo};
        pulse_start(3'b110, 10'd17);
        repeat (200) @(negedge clk);
        go_clr = 1'b1; @(negedge clk); go_clr = 1'b0;
        chk(!go_bit && !hold_open, "R7 abort clears go", go_bit, 0);
        chk({result_hi, result_lo} == prev && !done_flag, "R7 abort keeps result", {result_hi, result_lo}, prev);

        // R7 abort via disable
        pulse_start(3'b010, 10'd900);
        repeat (100) @(negedge clk);
        en = 1'b0; @(negedge clk);
        chk(!go_bit && {result_hi, result_lo} == prev && !done_flag, "R7 disable abort", go_bit, 0);
        en = 1'b1;

        // R2 free-running clock
        pulse_start(3'b011, 10'd777);
        wait_idle(2000, n);
        chk(!go_bit && {result_hi, result_lo} == 10'd777, "R2 alt clock result", {result_hi, result_lo}, 777);
        chk(done_flag, "R5 alt completion flag", done_flag, 1);

        // R8 completion wins over clear: keep flag_clr high until completion
        alt_run = 1'b0;
        pulse_start(3'b111, 10'd123);
        repeat (1000) @(negedge clk);
        chk(go_bit, "R2 stalled without alt clock", go_bit, 1);
        flag_clr = 1'b1;
        alt_run = 1'b1;
        wait_idle(2000, n);
        chk(done_flag, "R8 set wins over clear", done_flag, 1);
        flag_clr = 1'b0;
        chk({result_hi, result_lo} == 10'd123, "R2 result after restart", {result_hi, result_lo}, 123);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule